// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Tracker

This block keeps the single reservation of one hart for a load-reserved / store-conditional pair. It sits beside a cache that uses an invalidation-based coherence protocol. It watches two streams: the hart's own memory events (reserve, conditional store, plain load, plain store, eviction) and the snoops that other agents send for cache lines (a read that downgrades, a write that invalidates). It holds a valid bit, the reserved line address and a shadow of that line's coherence state. For every conditional store it returns a result code, a write enable and an indication of whether the write needs a bus upgrade.

Downgrades caused by other readers do not clear the reservation. Only an invalidation or the hart's own loss of the line clears it, so a crowd of readers cannot starve a writer. A configuration pin selects between a three-state protocol and a four-state protocol. In the four-state protocol a reservation acquires the line exclusively, and a conditional store to a line that is still exclusive completes silently, with no upgrade. Addresses are compared at cache-line granularity.

Top module: `rsv_tracker`

## Requirements
- R1: After reset, `resv_valid` is 0 and `sc_done`, `sc_fail`, `sc_write` and `sc_upgrade` are 0.
- R2: A local op with `op_kind`=0 (reserve) sets `resv_valid` and loads `resv_line` with the line of `op_addr` one cycle later. This replaces any earlier reservation.
- R3: A local op with `op_kind`=1 (conditional store) gives `sc_done`=1 on the next cycle. If the reservation is valid and on the same line, the result is `sc_fail`=0 and `sc_write`=1. Otherwise the result is `sc_fail`=1 and `sc_write`=0. `sc_done` is 0 on every other cycle.
- R4: Every conditional store clears the reservation, whatever its outcome.
- R5: A snoop read (`snp_inval`=0) on the reserved line leaves `resv_valid` and `resv_line` unchanged.
- R6: A snoop invalidate (`snp_inval`=1) on the reserved line clears the reservation. A snoop of either kind on another line has no effect.
- R7: A local op with `op_kind`=4 (eviction) on the reserved line clears the reservation. An eviction of another line has no effect.
- R8: Local ops with `op_kind`=2 (load) or 3 (store) never clear the reservation. Bits of an address below the line offset width never affect a line match.
- R9: `lr_excl` is 1 combinationally exactly when a reserve op is presented while `mode_mesi`=1.
- R10: A successful conditional store reports `sc_upgrade`=1 when the shadow line state is Shared and 0 when it is Exclusive or Modified. A reserve leaves the line Exclusive in four-state mode and Shared in three-state mode. A snoop read turns Exclusive or Modified into Shared. A local store to the reserved line makes it Modified.
- R11: A snoop in the same cycle as a local op takes effect first. An invalidate of the reserved line presented together with a conditional store to it makes that store fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_mesi | input | 1 | 1 selects four-state protocol behaviour, 0 selects three-state |
| op_valid | input | 1 | Local op present this cycle |
| op_kind | input | 3 | 0 reserve, 1 conditional store, 2 load, 3 store, 4 eviction, others no-op |
| op_addr | input | ADDR_W | Byte address of the local op |
| snp_valid | input | 1 | Snoop present this cycle |
| snp_inval | input | 1 | 1 invalidate (remote write), 0 read (downgrade) |
| snp_addr | input | ADDR_W | Byte address of the snoop |
| lr_excl | output | 1 | Reserve must fetch the line in Exclusive |
| sc_done | output | 1 | Conditional store result valid |
| sc_fail | output | 1 | Result code: 0 success, 1 failure |
| sc_write | output | 1 | Conditional store performs its write |
| sc_upgrade | output | 1 | Successful write needs a Shared-to-Modified upgrade |
| resv_valid | output | 1 | Reservation held |
| resv_line | output | ADDR_W-OFF_W | Reserved line address |

## Verification
The assertions assume that at most one local op and at most one snoop arrive per cycle. They also assume that the `op_kind` codes above 4 behave as idle. For snoop properties, they assume that no reserve arrives in the same cycle, because a reserve would re-arm the reservation after the snoop. The stimulus issues one local op and one optional snoop per cycle. It runs a sweep of reserve, then an intermediate event, then a conditional store. In that sweep the intermediate event and the snoop come from fixed sets of matching, same-line-offset and foreign addresses. The same-cycle snoop and reserve cases are checked only by the bench model.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic [2:0] {
        OPK_RESERVE = 3'd0,
        OPK_COND_ST = 3'd1,
        OPK_LOAD    = 3'd2,
        OPK_STORE   = 3'd3,
        OPK_EVICT   = 3'd4
    } opk_e;

    typedef enum logic [1:0] {
        LST_INV = 2'd0,
        LST_SHR = 2'd1,
        LST_EXC = 2'd2,
        LST_MOD = 2'd3
    } lst_e;

endpackage

// File: rtl/rsv_line_match.sv
module rsv_line_match #(
    parameter int LINE_W = 26
) (
    input  logic              held,
    input  logic [LINE_W-1:0] held_line,
    input  logic [LINE_W-1:0] probe_line,
    output logic              hit
);
    always_comb begin
        hit = held && (held_line == probe_line);
    end
endmodule

// File: rtl/rsv_sc_judge.sv
module rsv_sc_judge
    import rsv_pkg::*;
(
    input  logic valid_now,
    input  logic line_hit,
    input  lst_e state_now,
    output logic succeed,
    output logic need_upg
);
    always_comb begin
        succeed  = valid_now && line_hit;
        need_upg = succeed && (state_now == LST_SHR);
    end
endmodule

// File: rtl/rsv_tracker.sv
module rsv_tracker
    import rsv_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_mesi,
    input  logic                    op_valid,
    input  logic [2:0]              op_kind,
    input  logic [ADDR_W-1:0]       op_addr,
    input  logic                    snp_valid,
    input  logic                    snp_inval,
    input  logic [ADDR_W-1:0]       snp_addr,
    output logic                    lr_excl,
    output logic                    sc_done,
    output logic                    sc_fail,
    output logic                    sc_write,
    output logic                    sc_upgrade,
    output logic                    resv_valid,
    output logic [ADDR_W-OFF_W-1:0] resv_line
);
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam int NPROBE = 2;

    typedef struct packed {
        logic              vld;
        logic [LINE_W-1:0] line;
        lst_e              st;
        logic              done;
        logic              fail;
        logic              wr;
        logic              upg;
    } trk_s;

    trk_s cur_q, nxt_d;

    logic unused_lowbits;
    assign unused_lowbits = ^{op_addr[OFF_W-1:0], snp_addr[OFF_W-1:0]};

    logic [LINE_W-1:0] probe_line [NPROBE];
    logic [NPROBE-1:0] probe_hit;
    assign probe_line[0] = snp_addr[ADDR_W-1:OFF_W];
    assign probe_line[1] = op_addr[ADDR_W-1:OFF_W];

    // Probe 0 sees the registered reservation; probe 1 sees it after the snoop.
    logic held_after_snp;

    for (genvar g = 0; g < NPROBE; g++) begin : g_probe
        rsv_line_match #(.LINE_W(LINE_W)) match_i (
            .held       ((g == 0) ? cur_q.vld : held_after_snp),
            .held_line  (cur_q.line),
            .probe_line (probe_line[g]),
            .hit        (probe_hit[g])
        );
    end

    opk_e kind;
    assign kind = opk_e'(op_kind);

    logic snp_kill;
    lst_e st_after_snp;
    always_comb begin
        snp_kill     = snp_valid && snp_inval && probe_hit[0];
        st_after_snp = cur_q.st;
        if (snp_valid && !snp_inval && probe_hit[0]
            && (cur_q.st == LST_EXC || cur_q.st == LST_MOD)) begin
            st_after_snp = LST_SHR;
        end
        if (snp_kill) begin
            st_after_snp = LST_INV;
        end
        held_after_snp = cur_q.vld && !snp_kill;
    end

    logic sc_ok, sc_upg;
    rsv_sc_judge judge_i (
        .valid_now (held_after_snp),
        .line_hit  (probe_hit[1]),
        .state_now (st_after_snp),
        .succeed   (sc_ok),
        .need_upg  (sc_upg)
    );

    always_comb begin
        lr_excl = op_valid && (kind == OPK_RESERVE) && mode_mesi;
    end

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.vld  = held_after_snp;
        nxt_d.st   = st_after_snp;
        nxt_d.done = 1'b0;
        nxt_d.fail = 1'b0;
        nxt_d.wr   = 1'b0;
        nxt_d.upg  = 1'b0;
        if (op_valid) begin
            unique case (kind)
                OPK_RESERVE: begin
                    nxt_d.vld  = 1'b1;
                    nxt_d.line = probe_line[1];
                    nxt_d.st   = mode_mesi ? LST_EXC : LST_SHR;
                end
                OPK_COND_ST: begin
                    nxt_d.done = 1'b1;
                    nxt_d.fail = !sc_ok;
                    nxt_d.wr   = sc_ok;
                    nxt_d.upg  = sc_upg;
                    nxt_d.vld  = 1'b0;
                    nxt_d.st   = LST_INV;
                end
                OPK_STORE: begin
                    if (probe_hit[1]) begin
                        nxt_d.st = LST_MOD;
                    end
                end
                OPK_EVICT: begin
                    if (probe_hit[1]) begin
                        nxt_d.vld = 1'b0;
                        nxt_d.st  = LST_INV;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{vld: 1'b0, line: '0, st: LST_INV,
                       done: 1'b0, fail: 1'b0, wr: 1'b0, upg: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sc_done    = cur_q.done;
    assign sc_fail    = cur_q.fail;
    assign sc_write   = cur_q.wr;
    assign sc_upgrade = cur_q.upg;
    assign resv_valid = cur_q.vld;
    assign resv_line  = cur_q.line;

endmodule

// File: rtl/rsv_tracker_chk.sv
module rsv_tracker_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    mode_mesi,
    input logic                    op_valid,
    input logic [2:0]              op_kind,
    input logic [ADDR_W-1:0]       op_addr,
    input logic                    snp_valid,
    input logic                    snp_inval,
    input logic [ADDR_W-1:0]       snp_addr,
    input logic                    lr_excl,
    input logic                    sc_done,
    input logic                    sc_fail,
    input logic                    sc_write,
    input logic                    sc_upgrade,
    input logic                    resv_valid,
    input logic [ADDR_W-OFF_W-1:0] resv_line
);
    logic op_is_lr, op_is_sc, snp_on_resv, op_on_resv;
    assign op_is_lr    = op_valid && (op_kind == 3'd0);
    assign op_is_sc    = op_valid && (op_kind == 3'd1);
    assign snp_on_resv = snp_valid && resv_valid && (snp_addr[ADDR_W-1:OFF_W] == resv_line);
    assign op_on_resv  = resv_valid && (op_addr[ADDR_W-1:OFF_W] == resv_line);

    a_r2_reserve_sets: assert property (@(posedge clk) disable iff (!rst_n)
        op_is_lr |=> (resv_valid && resv_line == $past(op_addr[ADDR_W-1:OFF_W])));

    a_r3_done_after_sc: assert property (@(posedge clk) disable iff (!rst_n)
        op_is_sc |=> sc_done);

    a_r3_result_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        sc_done |-> (sc_write != sc_fail));

    a_r3_success_needs_resv: assert property (@(posedge clk) disable iff (!rst_n)
        op_is_sc && !resv_valid |=> sc_fail);

    a_r4_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        op_is_sc |=> !resv_valid);

    a_r5_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        snp_on_resv && !snp_inval && !op_valid |=> (resv_valid && $stable(resv_line)));

    a_r6_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
        snp_on_resv && snp_inval && !op_is_lr |=> !resv_valid);

    a_r7_evict_clears: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_kind == 3'd4 && op_on_resv && !snp_valid |=> !resv_valid);

    a_r9_excl_only_reserve: assert property (@(posedge clk) disable iff (!rst_n)
        lr_excl |-> (op_is_lr && mode_mesi));

    a_r10_upgrade_on_success: assert property (@(posedge clk) disable iff (!rst_n)
        sc_upgrade |-> (sc_done && !sc_fail));

    a_r11_inval_beats_sc: assert property (@(posedge clk) disable iff (!rst_n)
        op_is_sc && snp_on_resv && snp_inval |=> sc_fail);

endmodule

bind rsv_tracker rsv_tracker_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_mesi  (mode_mesi),
    .op_valid   (op_valid),
    .op_kind    (op_kind),
    .op_addr    (op_addr),
    .snp_valid  (snp_valid),
    .snp_inval  (snp_inval),
    .snp_addr   (snp_addr),
    .lr_excl    (lr_excl),
    .sc_done    (sc_done),
    .sc_fail    (sc_fail),
    .sc_write   (sc_write),
    .sc_upgrade (sc_upgrade),
    .resv_valid (resv_valid),
    .resv_line  (resv_line)
);

// File: tb/rsv_tracker_tb.sv
`timescale 1ns/1ps
module rsv_tracker_tb_top;
    localparam int ADDR_W = 32;
    localparam int OFF_W  = 6;
    localparam int LINE_W = ADDR_W - OFF_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_mesi = 1'b0;
    logic op_valid = 1'b0;
    logic [2:0] op_kind = 3'd0;
    logic [ADDR_W-1:0] op_addr = '0;
    logic snp_valid = 1'b0;
    logic snp_inval = 1'b0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic lr_excl, sc_done, sc_fail, sc_write, sc_upgrade, resv_valid;
    logic [LINE_W-1:0] resv_line;

    always #2 clk = ~clk;

    rsv_tracker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_mesi(mode_mesi),
        .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr),
        .snp_valid(snp_valid), .snp_inval(snp_inval), .snp_addr(snp_addr),
        .lr_excl(lr_excl), .sc_done(sc_done), .sc_fail(sc_fail),
        .sc_write(sc_write), .sc_upgrade(sc_upgrade),
        .resv_valid(resv_valid), .resv_line(resv_line)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // bench model of the reservation: state 0 I, 1 S, 2 E, 3 M
    bit m_v = 0;
    logic [LINE_W-1:0] m_line = '0;
    int m_st = 0;

    logic [ADDR_W-1:0] addr_tab [3];
    initial begin
        addr_tab[0] = 32'h1000_0040;
        addr_tab[1] = 32'h1000_007C; // same line, other offset
        addr_tab[2] = 32'h1000_0080; // next line
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // snp: 0 none, 1 read, 2 invalidate. Called at a negedge, returns at the next.
    task automatic step(input int kind, input logic [ADDR_W-1:0] a,
                        input int snp, input logic [ADDR_W-1:0] sa, input string tag);
        bit e_done, e_fail, e_wr, e_upg, hit;
        logic [LINE_W-1:0] la, ls;
        la = a[ADDR_W-1:OFF_W];
        ls = sa[ADDR_W-1:OFF_W];
        op_valid  = (kind >= 0);
        op_kind   = (kind >= 0) ? 3'(kind) : 3'd0;
        op_addr   = a;
        snp_valid = (snp != 0);
        snp_inval = (snp == 2);
        snp_addr  = sa;
        e_done = 0; e_fail = 0; e_wr = 0; e_upg = 0;
        // snoop first (R11)
        if (snp != 0 && m_v && ls == m_line) begin
            if (snp == 2) begin m_v = 0; m_st = 0; end
            else if (m_st >= 2) m_st = 1;
        end
        hit = m_v && (la == m_line);
        case (kind)
            0: begin m_v = 1; m_line = la; m_st = mode_mesi ? 2 : 1; end
            1: begin
                e_done = 1; e_fail = !hit; e_wr = hit; e_upg = hit && (m_st == 1);
                m_v = 0; m_st = 0;
            end
            3: if (hit) m_st = 3;
            4: if (hit) begin m_v = 0; m_st = 0; end
            default: ;
        endcase
        #1;
        chk("R9", lr_excl, (kind == 0) && mode_mesi);
        @(posedge clk);
        #1;
        chk(tag, sc_done, e_done);
        if (kind == 1) begin
            chk(tag, sc_fail, e_fail);
            chk(tag, sc_write, e_wr);
            chk("R10", sc_upgrade, e_upg);
            chk("R4", resv_valid, 0);
        end else begin
            chk(tag, resv_valid, m_v);
        end
        if (m_v) chk(tag, resv_line, m_line);
        @(negedge clk);
    endtask

    function automatic string mid_tag(input int k, input int s);
        if (s == 1) return "R5";
        if (s == 2) return "R6";
        case (k)
            0: return "R2";
            1: return "R3";
            4: return "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", resv_valid, 0);
        chk("R1", sc_done, 0);
        chk("R1", sc_fail, 0);
        chk("R1", sc_write, 0);
        chk("R1", sc_upgrade, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // SC with no reservation fails
        step(1, addr_tab[0], 0, addr_tab[0], "R3");
        for (int md = 0; md < 2; md++) begin
            mode_mesi = md[0];
            for (int k = 0; k < 5; k++)
                for (int ai = 0; ai < 3; ai++)
                    for (int s = 0; s < 3; s++)
                        for (int si = 0; si < 3; si += 2)
                            for (int ci = 0; ci < 3; ci++) begin
                                step(0, addr_tab[0], 0, addr_tab[2], "R2");
                                step(k, addr_tab[ai], s, addr_tab[si], mid_tag(k, s));
                                step(1, addr_tab[ci], 0, addr_tab[2], "R3");
                            end
            // same-cycle invalidate and SC (R11)
            step(0, addr_tab[0], 0, addr_tab[0], "R2");
            step(1, addr_tab[1], 2, addr_tab[0], "R11");
            // same-cycle read and SC: still succeeds, upgrade required (R11)
            step(0, addr_tab[0], 0, addr_tab[0], "R2");
            step(1, addr_tab[0], 1, addr_tab[1], "R11");
            // idle cycle with snoop only and no reservation
            step(-1, addr_tab[0], 2, addr_tab[0], "R6");
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule